// File: doc/BRIEF.md
# Test Access Port Controller with Extended Instruction Decoder

This block is a boundary-scan test access port controller clocked by TCK. A sixteen-state controller, steered by TMS, moves through capture, shift and update phases for both the instruction path and the data path. The 10-bit instruction register selects one of four data registers between TDI and TDO: a single-bit bypass stage, a 32-bit identification code, a 32-bit user code, or a boundary-scan chain whose length is a parameter. Serial data enters and leaves least significant bit first.

Besides the standard test instructions, the decoder recognises several pin-control opcodes. One floats every device pin. One holds the pins at the values in the boundary-scan update stage. One asks for a reconfiguration with a single-cycle strobe. One pulls an active-low status output down and keeps it there until the configuration logic reports completion. The pad drivers and the configuration engine are outside the block; they only read the control outputs.

Top module: `scan_tap`

## Requirements
- R1: While `trst_n` is low all outputs go at once to their idle values: `tdo_oe`, `pin_hiz`, `pin_bsr_sel` and `reconfig_pulse` low, `status_n` high, `bs_out` zero. The controller is in Test-Logic-Reset with the identification instruction current. Release takes effect on the second rising TCK edge after `trst_n` goes high.
- R2: Five rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state. There the identification instruction becomes current and every pin override is dropped.
- R3: Capture-IR loads 10'b00_0000_0001, so the first two bits shifted out are 1 and then 0, with zeros after them. A shifted opcode takes effect only on the falling TCK edge in Update-IR. Until then the previous instruction keeps control of the outputs.
- R4: TDO changes only on falling TCK edges. `tdo_oe` is high only while the controller is in Shift-DR or Shift-IR.
- R5: Opcode 10'h006 is the identification instruction. Capture-DR then loads the `IDCODE_VAL` parameter into a 32-bit register, which shifts out LSB first.
- R6: Opcode 10'h007 is the user-code instruction. Capture-DR then loads the `USERCODE_VAL` parameter into a 32-bit register, which shifts out LSB first.
- R7: Opcode 10'h3FF (all ones), opcodes 10'h001 and 10'h00D, and every opcode not listed in these requirements select the bypass stage. The bypass stage captures 0 and passes TDI to TDO one cycle later.
- R8: Opcodes 10'h005 (sample/preload) and 10'h000 (external test) select the boundary-scan chain. Capture-DR loads `bs_in`, with bit 0 leaving first. Update-DR copies the shifted chain to `bs_out`. `pin_bsr_sel` is high under 10'h000 and low under 10'h005.
- R9: Opcode 10'h00B selects bypass and holds `pin_hiz` high while it is current. `pin_bsr_sel` stays low.
- R10: Opcode 10'h00A selects bypass and holds `pin_bsr_sel` high. Data scans under it leave `bs_out` unchanged.
- R11: Opcode 10'h001 raises `reconfig_pulse` at the falling edge in Update-IR and holds it for exactly one TCK cycle.
- R12: Opcode 10'h00D drives `status_n` low from its Update-IR. It stays low through later instructions and through Test-Logic-Reset, and goes high only after `cfg_done` is seen high on a falling TCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| bs_in | input | BSR_W | Pin values captured into the boundary-scan chain |
| cfg_done | input | 1 | Configuration-complete indication, releases the status hold |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_oe | output | 1 | Output enable for TDO |
| pin_hiz | output | 1 | Float all device pins |
| pin_bsr_sel | output | 1 | Drive device pins from `bs_out` |
| bs_out | output | BSR_W | Boundary-scan update stage |
| reconfig_pulse | output | 1 | One-cycle reconfiguration request |
| status_n | output | 1 | Active-low status hold |

## Verification
The status hold is the hardest behaviour to reach. It outlives instruction changes and controller resets, so the bench must issue the configuration opcode, overwrite it with another instruction, walk the controller into Test-Logic-Reset with TMS high, and only then pulse `cfg_done`. The falling-edge timing of TDO is checked by stopping inside Shift-DR and sampling once between the rising and falling edges and once after the falling edge. The deferred instruction update is checked by parking in Exit1-IR, where a new opcode has been shifted in but must not yet have effect.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;

  localparam int IR_W = 10;
  typedef logic [IR_W-1:0] ir_t;

  // opcode map; these values are decoded by external test software
  localparam ir_t OP_EXTEST  = 10'h000;
  localparam ir_t OP_PULSE   = 10'h001;
  localparam ir_t OP_SAMPLE  = 10'h005;
  localparam ir_t OP_IDCODE  = 10'h006;
  localparam ir_t OP_USER    = 10'h007;
  localparam ir_t OP_CLAMP   = 10'h00A;
  localparam ir_t OP_HIGHZ   = 10'h00B;
  localparam ir_t OP_CFGIO   = 10'h00D;
  localparam ir_t OP_BYPASS  = 10'h3FF;
  localparam ir_t IR_CAPTURE = 10'h001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_e;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_USER, DR_BSR} dr_sel_e;

  function automatic dr_sel_e decode_dr(input ir_t op);
    case (op)
      OP_IDCODE:             return DR_ID;
      OP_USER:               return DR_USER;
      OP_SAMPLE, OP_EXTEST:  return DR_BSR;
      default:               return DR_BYP;
    endcase
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
`timescale 1ns/1ps
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic    tck,
  input  logic    rst_n,
  input  logic    tms,
  output tap_st_e st
);

  tap_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_TLR:    st_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    st_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: st_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: st_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  st_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: st_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: st_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: st_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: st_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: st_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: st_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  st_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: st_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: st_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: st_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: st_d = tms ? ST_SEL_DR : ST_RTI;
      default:   st_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) st_q <= ST_TLR;
    else        st_q <= st_d;
  end

  assign st = st_q;

endmodule

// File: rtl/scan_tap_ir.sv
`timescale 1ns/1ps
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic    tck,
  input  logic    rst_n,
  input  tap_st_e st,
  input  logic    tdi,
  input  logic    cfg_done,
  output logic    ir_lsb,
  output dr_sel_e dr_sel,
  output logic    pin_hiz,
  output logic    pin_bsr_sel,
  output logic    reconfig_pulse,
  output logic    status_n
);

  // shift stage, rising edge
  ir_t  sh_q, sh_d;
  logic sh_en;

  always_comb begin
    sh_en = (st == ST_CAP_IR) || (st == ST_SH_IR);
    sh_d  = (st == ST_CAP_IR) ? IR_CAPTURE : {tdi, sh_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  // current instruction and strobes, falling edge
  ir_t  cur_q, cur_d;
  logic cur_en, upd;
  logic pls_q, pls_d;
  logic hold_q, hold_d, hold_en;

  always_comb begin
    upd     = (st == ST_UPD_IR);
    cur_en  = upd || (st == ST_TLR);
    cur_d   = (st == ST_TLR) ? OP_IDCODE : sh_q;
    pls_d   = upd && (sh_q == OP_PULSE);
    hold_en = (upd && (sh_q == OP_CFGIO)) || cfg_done;
    hold_d  = upd && (sh_q == OP_CFGIO);
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      cur_q <= OP_IDCODE;
    else if (cur_en) cur_q <= cur_d;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) pls_q <= 1'b0;
    else        pls_q <= pls_d;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)       hold_q <= 1'b0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign ir_lsb         = sh_q[0];
  assign dr_sel         = decode_dr(cur_q);
  assign pin_hiz        = (cur_q == OP_HIGHZ);
  assign pin_bsr_sel    = (cur_q == OP_CLAMP) || (cur_q == OP_EXTEST);
  assign reconfig_pulse = pls_q;
  assign status_n       = ~hold_q;

endmodule

// File: rtl/scan_tap_dr.sv
`timescale 1ns/1ps
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int              BSR_W        = 8,
  parameter int              CODE_W       = 32,
  parameter logic [CODE_W-1:0] IDCODE_VAL   = '1,
  parameter logic [CODE_W-1:0] USERCODE_VAL = '0
) (
  input  logic             tck,
  input  logic             rst_n,
  input  tap_st_e          st,
  input  logic             tdi,
  input  dr_sel_e          dr_sel,
  input  logic [BSR_W-1:0] bs_in,
  output logic             dr_tdo,
  output logic [BSR_W-1:0] bs_out
);

  logic cap, sh, upd;
  assign cap = (st == ST_CAP_DR);
  assign sh  = (st == ST_SH_DR);
  assign upd = (st == ST_UPD_DR);

  // bypass stage
  logic byp_q, byp_d, byp_en;
  assign byp_en = (cap || sh) && (dr_sel == DR_BYP);
  assign byp_d  = sh ? tdi : 1'b0;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  // one shift register serves both code registers
  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;
  assign code_en = (cap || sh) && ((dr_sel == DR_ID) || (dr_sel == DR_USER));

  always_comb begin
    if (cap) code_d = (dr_sel == DR_ID) ? IDCODE_VAL : USERCODE_VAL;
    else     code_d = {tdi, code_q[CODE_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  // boundary-scan cells
  logic [BSR_W-1:0] bsr_q, bsr_d, hold_q;
  logic             bsr_en, hold_en;
  assign bsr_en  = (cap || sh) && (dr_sel == DR_BSR);
  assign hold_en = upd && (dr_sel == DR_BSR);

  for (genvar i = 0; i < BSR_W; i++) begin : g_cell
    logic ser_in;
    if (i == BSR_W-1) begin : g_head
      assign ser_in = tdi;
    end else begin : g_body
      assign ser_in = bsr_q[i+1];
    end
    assign bsr_d[i] = cap ? bs_in[i] : ser_in;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      bsr_q <= '0;
    else if (bsr_en) bsr_q <= bsr_d;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= bsr_q;
  end

  always_comb begin
    case (dr_sel)
      DR_ID, DR_USER: dr_tdo = code_q[0];
      DR_BSR:         dr_tdo = bsr_q[0];
      default:        dr_tdo = byp_q;
    endcase
  end

  assign bs_out = hold_q;

endmodule

// File: rtl/scan_tap.sv
`timescale 1ns/1ps
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int                BSR_W        = 8,
  parameter int                CODE_W       = 32,
  parameter logic [CODE_W-1:0] IDCODE_VAL   = 32'h020B_10DD,
  parameter logic [CODE_W-1:0] USERCODE_VAL = 32'hC0DE_5A5A
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic [BSR_W-1:0] bs_in,
  input  logic             cfg_done,
  output logic             tdo,
  output logic             tdo_oe,
  output logic             pin_hiz,
  output logic             pin_bsr_sel,
  output logic [BSR_W-1:0] bs_out,
  output logic             reconfig_pulse,
  output logic             status_n
);

  // reset: asserted asynchronously, released on TCK
  logic rst_meta, rst_n;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) {rst_meta, rst_n} <= 2'b00;
    else         {rst_meta, rst_n} <= {1'b1, rst_meta};
  end

  tap_st_e st;
  dr_sel_e dr_sel;
  logic    ir_lsb, dr_tdo;

  scan_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .st    (st)
  );

  scan_tap_ir u_ir (
    .tck            (tck),
    .rst_n          (rst_n),
    .st             (st),
    .tdi            (tdi),
    .cfg_done       (cfg_done),
    .ir_lsb         (ir_lsb),
    .dr_sel         (dr_sel),
    .pin_hiz        (pin_hiz),
    .pin_bsr_sel    (pin_bsr_sel),
    .reconfig_pulse (reconfig_pulse),
    .status_n       (status_n)
  );

  scan_tap_dr #(
    .BSR_W        (BSR_W),
    .CODE_W       (CODE_W),
    .IDCODE_VAL   (IDCODE_VAL),
    .USERCODE_VAL (USERCODE_VAL)
  ) u_dr (
    .tck    (tck),
    .rst_n  (rst_n),
    .st     (st),
    .tdi    (tdi),
    .dr_sel (dr_sel),
    .bs_in  (bs_in),
    .dr_tdo (dr_tdo),
    .bs_out (bs_out)
  );

  // serial output, falling edge
  logic tdo_q, oe_q, oe_d, tdo_d;
  assign oe_d  = (st == ST_SH_DR) || (st == ST_SH_IR);
  assign tdo_d = (st == ST_SH_IR) ? ir_lsb : dr_tdo;

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= oe_d;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)    tdo_q <= 1'b0;
    else if (oe_d) tdo_q <= tdo_d;
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

endmodule

// File: rtl/scan_tap_chk.sv
`timescale 1ns/1ps
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic    tck,
  input logic    rst_n,
  input logic    tms,
  input tap_st_e st,
  input logic    tdo_oe,
  input logic    pin_hiz,
  input logic    pin_bsr_sel,
  input logic    reconfig_pulse,
  input logic    status_n,
  input logic    cfg_done
);

  // run of consecutive TMS-high edges, saturating at five
  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)              ones_q <= 3'd0;
    else if (!tms)           ones_q <= 3'd0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
  end

  // R2
  p_tlr_reach_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_q == 3'd5) |-> (st == ST_TLR))
    else $error("five TMS-high edges did not reach Test-Logic-Reset");

  // R3
  p_ir_stable_r3: assert property (@(negedge tck) disable iff (!rst_n)
    (st != ST_UPD_IR && st != ST_TLR) |=> ($stable(pin_hiz) && $stable(pin_bsr_sel)))
    else $error("pin controls changed outside Update-IR");

  // R4
  p_oe_shift_only_r4: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (st == ST_SH_DR || st == ST_SH_IR))
    else $error("TDO enabled outside a shift state");

  // R11
  p_pulse_single_r11: assert property (@(posedge tck) disable iff (!rst_n)
    reconfig_pulse |=> !reconfig_pulse)
    else $error("reconfiguration pulse longer than one cycle");

  // R11
  p_pulse_in_update_r11: assert property (@(posedge tck) disable iff (!rst_n)
    reconfig_pulse |-> (st == ST_UPD_IR))
    else $error("reconfiguration pulse not tied to Update-IR");

  // R12
  p_status_hold_r12: assert property (@(negedge tck) disable iff (!rst_n)
    (!status_n && !cfg_done) |=> !status_n)
    else $error("status hold released without cfg_done");

endmodule

bind scan_tap scan_tap_chk u_chk (
  .tck            (tck),
  .rst_n          (rst_n),
  .tms            (tms),
  .st             (st),
  .tdo_oe         (tdo_oe),
  .pin_hiz        (pin_hiz),
  .pin_bsr_sel    (pin_bsr_sel),
  .reconfig_pulse (reconfig_pulse),
  .status_n       (status_n),
  .cfg_done       (cfg_done)
);

// File: tb/scan_tap_tb.sv
`timescale 1ns/1ps
module scan_tap_tb;

  localparam int          BSR_W = 8;
  localparam logic [31:0] IDV   = 32'h020B_10DD;
  localparam logic [31:0] UCV   = 32'hC0DE_5A5A;

  logic tck, trst_n, tms, tdi, cfg_done;
  logic [BSR_W-1:0] bs_in, bs_out;
  logic tdo, tdo_oe, pin_hiz, pin_bsr_sel, reconfig_pulse, status_n;

  int n_chk = 0;
  int n_bad = 0;

  scan_tap #(.BSR_W(BSR_W), .CODE_W(32), .IDCODE_VAL(IDV), .USERCODE_VAL(UCV)) u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bs_in(bs_in), .cfg_done(cfg_done),
    .tdo(tdo), .tdo_oe(tdo_oe), .pin_hiz(pin_hiz), .pin_bsr_sel(pin_bsr_sel),
    .bs_out(bs_out), .reconfig_pulse(reconfig_pulse), .status_n(status_n)
  );

  initial tck = 1'b0;
  always #5 tck = ~tck;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // from Run-Test/Idle to Exit1-IR, returns captured bits
  task automatic shift_ir(input logic [9:0] op, output logic [9:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 10; i++) begin
      cap[i] = tdo;
      tick(i == 9, op[i]);
    end
  endtask

  task automatic load_ir(input logic [9:0] op);
    logic [9:0] c;
    shift_ir(op, c);
    tick(1, 0);
    tick(0, 0);
  endtask

  // from Run-Test/Idle through a data scan back to Run-Test/Idle
  task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] got);
    got = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      got[i] = tdo;
      if (i == 0) chk("R4 oe high in Shift-DR", {31'd0, tdo_oe}, 32'd1);
      tick(i == n-1, din[i]);
    end
    tick(1, 0);
    tick(0, 0);
  endtask

  function automatic logic [31:0] byp_exp(input int n, input logic [31:0] din);
    return (din << 1) & ((32'd1 << n) - 32'd1);
  endfunction

  task automatic do_reset();
    trst_n = 1'b0;
    repeat (3) tick(1, 0);
    trst_n = 1'b1;
    repeat (3) tick(1, 0);
  endtask

  task automatic t_reset();
    logic [31:0] g;
    do_reset();
    chk("R1 tdo_oe", {31'd0, tdo_oe}, 32'd0);
    chk("R1 pin_hiz", {31'd0, pin_hiz}, 32'd0);
    chk("R1 pin_bsr_sel", {31'd0, pin_bsr_sel}, 32'd0);
    chk("R1 pulse", {31'd0, reconfig_pulse}, 32'd0);
    chk("R1 status_n", {31'd0, status_n}, 32'd1);
    chk("R1 bs_out", {24'd0, bs_out}, 32'd0);
    tick(0, 0);
    shift_dr(32, 32'hFFFF_0000, g);
    chk("R1 R5 id after reset", g, IDV);
  endtask

  task automatic t_ir_capture();
    logic [9:0] c;
    shift_ir(10'h00B, c);
    chk("R3 capture pattern", {22'd0, c}, 32'h001);
    chk("R3 no effect before update", {31'd0, pin_hiz}, 32'd0);
    tick(1, 0);
    chk("R3 R9 effect at update", {31'd0, pin_hiz}, 32'd1);
    tick(0, 0);
  endtask

  task automatic t_highz();
    logic [31:0] g;
    chk("R9 bsr_sel low", {31'd0, pin_bsr_sel}, 32'd0);
    shift_dr(5, 32'h0000_0017, g);
    chk("R9 bypass path", g, byp_exp(5, 32'h17));
    chk("R9 hiz still high", {31'd0, pin_hiz}, 32'd1);
  endtask

  task automatic t_codes();
    logic [31:0] g;
    load_ir(10'h006);
    shift_dr(32, 32'h1234_5678, g);
    chk("R5 idcode", g, IDV);
    load_ir(10'h007);
    shift_dr(32, 32'h0, g);
    chk("R6 usercode", g, UCV);
    shift_dr(32, 32'hFFFF_FFFF, g);
    chk("R6 usercode recaptured", g, UCV);
  endtask

  task automatic t_bypass();
    logic [31:0] g;
    load_ir(10'h3FF);
    shift_dr(6, 32'h2D, g);
    chk("R7 all-ones bypass", g, byp_exp(6, 32'h2D));
    load_ir(10'h155);
    shift_dr(7, 32'h5B, g);
    chk("R7 undefined opcode bypass", g, byp_exp(7, 32'h5B));
    load_ir(10'h0C7);
    shift_dr(4, 32'hF, g);
    chk("R7 second undefined opcode", g, byp_exp(4, 32'hF));
  endtask

  task automatic t_tdo_edge();
    load_ir(10'h3FF);
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R4 captured zero", {31'd0, tdo}, 32'd0);
    tms = 1'b0; tdi = 1'b1;
    @(posedge tck); #2;
    chk("R4 tdo held at rising edge", {31'd0, tdo}, 32'd0);
    @(negedge tck); #1;
    chk("R4 tdo moves at falling edge", {31'd0, tdo}, 32'd1);
    tick(1, 0); tick(1, 0); tick(0, 0);
    chk("R4 oe low in idle", {31'd0, tdo_oe}, 32'd0);
  endtask

  task automatic t_bsr();
    logic [31:0] g;
    bs_in = 8'hC5;
    load_ir(10'h005);
    chk("R8 sample no override", {31'd0, pin_bsr_sel}, 32'd0);
    shift_dr(BSR_W, 32'h3A, g);
    chk("R8 sample capture", g, 32'hC5);
    chk("R8 sample update", {24'd0, bs_out}, 32'h3A);
    bs_in = 8'h5E;
    load_ir(10'h000);
    chk("R8 extest override", {31'd0, pin_bsr_sel}, 32'd1);
    shift_dr(BSR_W, 32'h96, g);
    chk("R8 extest capture", g, 32'h5E);
    chk("R8 extest update", {24'd0, bs_out}, 32'h96);
  endtask

  task automatic t_clamp();
    logic [31:0] g;
    load_ir(10'h00A);
    chk("R10 clamp select", {31'd0, pin_bsr_sel}, 32'd1);
    chk("R10 clamp no hiz", {31'd0, pin_hiz}, 32'd0);
    shift_dr(8, 32'hA5, g);
    chk("R10 clamp bypass", g, byp_exp(8, 32'hA5));
    chk("R10 bs_out kept", {24'd0, bs_out}, 32'h96);
  endtask

  task automatic t_pulse();
    logic [9:0] c;
    logic [31:0] g;
    shift_ir(10'h001, c);
    chk("R11 low before update", {31'd0, reconfig_pulse}, 32'd0);
    tick(1, 0);
    chk("R11 high in update", {31'd0, reconfig_pulse}, 32'd1);
    tick(0, 0);
    chk("R11 low after one cycle", {31'd0, reconfig_pulse}, 32'd0);
    tick(0, 0);
    chk("R11 stays low", {31'd0, reconfig_pulse}, 32'd0);
    shift_dr(3, 32'h5, g);
    chk("R7 pulse opcode bypass", g, byp_exp(3, 32'h5));
  endtask

  task automatic t_status();
    load_ir(10'h00D);
    chk("R12 status low", {31'd0, status_n}, 32'd0);
    load_ir(10'h006);
    chk("R12 kept across instruction", {31'd0, status_n}, 32'd0);
    repeat (5) tick(1, 0);
    tick(0, 0);
    chk("R12 kept across reset state", {31'd0, status_n}, 32'd0);
    cfg_done = 1'b1;
    tick(0, 0);
    cfg_done = 1'b0;
    chk("R12 released by cfg_done", {31'd0, status_n}, 32'd1);
  endtask

  task automatic t_tlr();
    logic [31:0] g;
    load_ir(10'h00B);
    chk("R2 hiz set", {31'd0, pin_hiz}, 32'd1);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    repeat (5) tick(1, 0);
    chk("R2 hiz dropped", {31'd0, pin_hiz}, 32'd0);
    chk("R2 bsr_sel dropped", {31'd0, pin_bsr_sel}, 32'd0);
    tick(0, 0);
    shift_dr(32, 32'h0, g);
    chk("R2 idcode current", g, IDV);
  endtask

  task automatic t_trst();
    logic [31:0] g;
    load_ir(10'h00B);
    tick(1, 0); tick(0, 0); tick(0, 0);
    trst_n = 1'b0;
    #1;
    chk("R1 async hiz", {31'd0, pin_hiz}, 32'd0);
    chk("R1 async oe", {31'd0, tdo_oe}, 32'd0);
    do_reset();
    tick(0, 0);
    shift_dr(32, 32'h0, g);
    chk("R1 idcode after trst", g, IDV);
  endtask

  initial begin
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; cfg_done = 1'b0; bs_in = '0;
    t_reset();
    t_ir_capture();
    t_highz();
    t_codes();
    t_bypass();
    t_tdo_edge();
    t_bsr();
    t_clamp();
    t_pulse();
    t_status();
    t_tlr();
    t_trst();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule